// File: doc/BRIEF.md
# Sampling Tap Window Selector

This block picks the sampling-clock phase used to capture read data after a phase sweep. The sweep probes each of `NTAP` taps twice. Probe `i` uses tap `i % NTAP`, so there are `2*NTAP` probes. The sweep hands the block two bitmaps of that width. `cmd_ok` has a bit set when the probe's tuning command succeeded. `cmp_ok` has a bit set when the probe's sampled-data comparison matched. Bit `i` of each bitmap belongs to probe `i`.

On a `start` pulse the block captures both bitmaps. It first folds them so that a tap counts as good only when both of its probes were good. It then walks the folded command bitmap one bit per cycle and tracks the longest run of consecutive set bits. If every probe is good, the command bitmap cannot tell the taps apart. The block then walks the folded comparison bitmap in the same way.

The chosen tap is the centre of the winning run, folded back into the tap range. If no acceptable run exists, the block raises `err` together with `done` and keeps the tap it selected before. Supported tap counts are 4 and 8.

Top module: `tapsel_window_select`

## Requirements
- R1: After reset, `tap_sel` is 0 and `done`, `err` and `busy` are 0.
- R2: Tap `t` counts as good only when bits `t` and `t+NTAP` are both set. When either is clear, both bits are treated as clear. This folding is applied to `cmd_ok` and also to `cmp_ok`.
- R3: The search finds the longest run of consecutive set bits from bit 0 to bit `2*NTAP-1`. A later run replaces the best run only when it is strictly longer, so the earliest of several equally long runs wins.
- R4: A run is made of consecutive probe indices. A run that crosses from probe `NTAP-1` to probe `NTAP` is one run. A run that ends on the last bit is also a candidate.
- R5: When not every probe is good, selection succeeds only if the longest run is at least 3 probes long. Otherwise `err` is raised.
- R6: When every folded command bit is set, the longest run of the folded comparison bitmap is used instead. Selection then succeeds if and only if that run is non-empty.
- R7: On success, `tap_sel` = ((first index of the run + last index of the run) / 2) % NTAP, using integer division.
- R8: `err` is high only in a cycle where `done` is high. On failure, `tap_sel` keeps its previous value. `tap_sel` changes only in a successful `done` cycle.
- R9: `start` is acted on only while `busy` is low, and the bitmaps are captured in that cycle. `start` pulses during a selection, and later changes to the bitmaps, have no effect.
- R10: `done` is a one-cycle pulse. It appears `2*NTAP` clock edges after the start edge when the command bitmap decides the result. It appears `4*NTAP` edges after the start edge when the comparison bitmap is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a selection; ignored while busy |
| cmd_ok | input | 2*NTAP | Per-probe tuning-command success bitmap |
| cmp_ok | input | 2*NTAP | Per-probe data-comparison match bitmap |
| busy | output | 1 | Selection in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No acceptable window; valid with done |
| tap_sel | output | $clog2(NTAP) | Selected sampling tap |

## Verification
The search is tried with windows in several positions:
- a window inside one half of the sweep;
- a window that wraps across the half boundary, which only counts correctly if the run spans probes `NTAP-1` and `NTAP`;
- two equal windows, which show whether the earliest run wins;
- windows of exactly three probes and of two probes, which bracket the length threshold.

Bitmaps in which a tap fails in only one of its two passes show whether the folding step is applied. All-pass command bitmaps paired with empty, single-tap, one-sided and full comparison bitmaps exercise the fallback path and the run that ends on the last bit. A start pulse during a selection, and bitmaps changed mid-scan, show that captured inputs alone decide the result.

// File: rtl/tapsel_pkg.sv
package tapsel_pkg;

    // Default number of sampling taps.
    localparam int DEF_NTAP    = 8;
    // Minimum window length accepted from the command bitmap.
    localparam int DEF_MIN_RUN = 3;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SCAN_CMD = 2'd1,
        ST_SCAN_CMP = 2'd2
    } scan_st_e;

endpackage

// File: rtl/tapsel_merge.sv
// Folds the two passes of each tap: a probe stays set only if the probe
// of the same tap in the other half is set as well.
module tapsel_merge #(
    parameter int NTAP = 8,
    localparam int NP  = 2 * NTAP
) (
    input  logic [NP-1:0] raw,
    output logic [NP-1:0] merged
);

    for (genvar i = 0; i < NP; i++) begin : g_fold
        assign merged[i] = raw[i % NTAP] & raw[(i % NTAP) + NTAP];
    end

endmodule

// File: rtl/tapsel_run_step.sv
// One step of the longest-run search: consumes one bitmap bit and
// updates the current run length and the best window seen so far.
module tapsel_run_step #(
    parameter int NP = 16,
    localparam int IW = $clog2(NP),
    localparam int CW = $clog2(NP + 1)
) (
    input  logic          bit_in,
    input  logic          is_last,
    input  logic [IW-1:0] idx,
    input  logic [CW-1:0] run_len,
    input  logic [CW-1:0] best_len,
    input  logic [IW-1:0] best_lo,
    input  logic [IW-1:0] best_hi,
    output logic [CW-1:0] run_nx,
    output logic [CW-1:0] best_nx,
    output logic [IW-1:0] lo_nx,
    output logic [IW-1:0] hi_nx
);

    logic [CW-1:0] run_inc;
    logic [CW-1:0] lo_wide;

    assign run_inc = run_len + 1'b1;

    always_comb begin
        run_nx  = run_len;
        best_nx = best_len;
        lo_nx   = best_lo;
        hi_nx   = best_hi;
        lo_wide = '0;
        if (bit_in) begin
            run_nx = run_inc;
            // A run reaching the final bit is closed here.
            if (is_last && (run_inc > best_len)) begin
                best_nx = run_inc;
                lo_wide = CW'(NP) - run_inc;
                lo_nx   = lo_wide[IW-1:0];
                hi_nx   = IW'(NP - 1);
            end
        end else begin
            run_nx = '0;
            if (run_len > best_len) begin
                best_nx = run_len;
                lo_wide = CW'(idx) - run_len;
                lo_nx   = lo_wide[IW-1:0];
                hi_nx   = idx - 1'b1;
            end
        end
    end

endmodule

// File: rtl/tapsel_center.sv
// Midpoint of a window, folded back into the tap range.
module tapsel_center #(
    parameter int NTAP = 8,
    localparam int NP  = 2 * NTAP,
    localparam int IW  = $clog2(NP),
    localparam int TW  = $clog2(NTAP)
) (
    input  logic [IW-1:0] lo,
    input  logic [IW-1:0] hi,
    output logic [TW-1:0] tap
);

    logic [IW:0]   sum;
    logic [IW-1:0] mid;
    logic [31:0]   folded;

    assign sum    = {1'b0, lo} + {1'b0, hi};
    assign mid    = sum[IW:1];
    assign folded = 32'(mid) % NTAP;
    assign tap    = folded[TW-1:0];

endmodule

// File: rtl/tapsel_window_select.sv
module tapsel_window_select
    import tapsel_pkg::*;
#(
    parameter int NTAP    = DEF_NTAP,
    parameter int MIN_RUN = DEF_MIN_RUN,
    localparam int NP     = 2 * NTAP,
    localparam int IW     = $clog2(NP),
    localparam int CW     = $clog2(NP + 1),
    localparam int TW     = $clog2(NTAP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NP-1:0] cmd_ok,
    input  logic [NP-1:0] cmp_ok,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [TW-1:0] tap_sel
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NP - 1);

    typedef struct packed {
        scan_st_e      st;
        logic [IW-1:0] idx;
        logic [CW-1:0] run;
        logic [CW-1:0] best;
        logic [IW-1:0] lo;
        logic [IW-1:0] hi;
        logic [NP-1:0] vec_cmd;
        logic [NP-1:0] vec_cmp;
        logic [TW-1:0] tap;
        logic          done;
        logic          err;
    } sel_state_t;

    sel_state_t s_d, s_q;

    logic [NP-1:0] fold_cmd, fold_cmp;
    logic          cur_bit, at_last;
    logic [CW-1:0] run_nx, best_nx;
    logic [IW-1:0] lo_nx, hi_nx;
    logic [TW-1:0] mid_tap;

    tapsel_merge #(.NTAP(NTAP)) u_fold_cmd (.raw(cmd_ok), .merged(fold_cmd));
    tapsel_merge #(.NTAP(NTAP)) u_fold_cmp (.raw(cmp_ok), .merged(fold_cmp));

    assign cur_bit = (s_q.st == ST_SCAN_CMP) ? s_q.vec_cmp[s_q.idx]
                                             : s_q.vec_cmd[s_q.idx];
    assign at_last = (s_q.idx == LAST_IDX);

    tapsel_run_step #(.NP(NP)) u_step (
        .bit_in   (cur_bit),
        .is_last  (at_last),
        .idx      (s_q.idx),
        .run_len  (s_q.run),
        .best_len (s_q.best),
        .best_lo  (s_q.lo),
        .best_hi  (s_q.hi),
        .run_nx   (run_nx),
        .best_nx  (best_nx),
        .lo_nx    (lo_nx),
        .hi_nx    (hi_nx)
    );

    tapsel_center #(.NTAP(NTAP)) u_center (
        .lo  (lo_nx),
        .hi  (hi_nx),
        .tap (mid_tap)
    );

    always_comb begin
        logic accept;
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        accept   = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st      = ST_SCAN_CMD;
                    s_d.vec_cmd = fold_cmd;
                    s_d.vec_cmp = fold_cmp;
                    s_d.idx     = '0;
                    s_d.run     = '0;
                    s_d.best    = '0;
                    s_d.lo      = '0;
                    s_d.hi      = '0;
                end
            end
            ST_SCAN_CMD, ST_SCAN_CMP: begin
                s_d.run  = run_nx;
                s_d.best = best_nx;
                s_d.lo   = lo_nx;
                s_d.hi   = hi_nx;
                if (!at_last) begin
                    s_d.idx = s_q.idx + 1'b1;
                end else if ((s_q.st == ST_SCAN_CMD) && (best_nx == CW'(NP))) begin
                    // Every probe passed: rank by data comparison instead.
                    s_d.st   = ST_SCAN_CMP;
                    s_d.idx  = '0;
                    s_d.run  = '0;
                    s_d.best = '0;
                    s_d.lo   = '0;
                    s_d.hi   = '0;
                end else begin
                    if (s_q.st == ST_SCAN_CMD) begin
                        accept = (best_nx >= CW'(MIN_RUN));
                    end else begin
                        accept = (best_nx != '0);
                    end
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                    s_d.err  = !accept;
                    if (accept) begin
                        s_d.tap = mid_tap;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.st != ST_IDLE);
    assign done    = s_q.done;
    assign err     = s_q.err;
    assign tap_sel = s_q.tap;

endmodule

// File: rtl/tapsel_checker.sv
module tapsel_checker #(
    parameter int TW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [TW-1:0] tap_sel
);

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: error is only reported alongside done
    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R8: tap moves only on a successful completion
    p_tap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!done || err) |-> $stable(tap_sel));

    // R9: a start during a selection does not restart or abort it
    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R9: a selection only begins from a start request
    p_busy_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R10: done marks the end of a selection
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind tapsel_window_select tapsel_checker #(.TW(TW)) u_tapsel_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .err     (err),
    .tap_sel (tap_sel)
);

// File: tb/test_tapsel_window_select.sv
module test_tapsel_window_select;

    localparam int NTAP = 8;
    localparam int NP   = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NP-1:0] cmd_ok = '0;
    logic [NP-1:0] cmp_ok = '0;
    logic          busy, done, err;
    logic [2:0]    tap_sel;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tapsel_window_select #(.NTAP(NTAP)) i_tapsel_window_select (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_ok(cmd_ok),
        .cmp_ok(cmp_ok), .busy(busy), .done(done), .err(err), .tap_sel(tap_sel)
    );

    // Vector: cmd[35:20] cmp[19:4] err[3] tap[2:0] ; latency 1 = fallback
    localparam int NV = 11;
    localparam logic [35:0] VEC [NV] = '{
        {16'h1E1E, 16'h0000, 1'b0, 3'd2},  // R2 R7: taps 1..4
        {16'hFFFF, 16'h0000, 1'b1, 3'd2},  // R6: all pass, empty compare -> err, R8 hold
        {16'hFFFF, 16'h3C3C, 1'b0, 3'd3},  // R6 R3: two equal compare runs, earliest
        {16'h0303, 16'hFFFF, 1'b1, 3'd3},  // R5: only two-probe runs -> err
        {16'hF0FF, 16'h0000, 1'b0, 3'd5},  // R2: one-sided passes dropped, R3 tie
        {16'hC3C3, 16'h0000, 1'b0, 3'd7},  // R4: run wraps probes 6..9
        {16'h7F7F, 16'h0000, 1'b0, 3'd3},  // R3: seven-long runs
        {16'hE0E0, 16'h0000, 1'b0, 3'd6},  // R5: exactly three
        {16'hFFFF, 16'hFFFF, 1'b0, 3'd7},  // R4 R6: run ending on last bit
        {16'hFFFF, 16'h1010, 1'b0, 3'd4},  // R6: single-tap compare run
        {16'hFFFF, 16'h00F0, 1'b1, 3'd4}   // R2 R6: compare folded to empty
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Start a selection, scramble inputs afterwards, return edges to done.
    task automatic run_sel(input logic [NP-1:0] c, input logic [NP-1:0] m,
                           output int lat);
        @(negedge clk);
        start = 1'b1; cmd_ok = c; cmp_ok = m;
        @(negedge clk);
        start = 1'b0; cmd_ok = ~c; cmp_ok = ~m;  // R9: must not matter
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        int wd = 0;
        while (!finished) begin
            @(posedge clk);
            wd++;
            if (wd > 200000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", wd, 200000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        int lat;
        int ndone;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tap_sel == 0, "R1 tap", tap_sel, 0);
        check(!done && !err && !busy, "R1 flags", {done, err, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [15:0] c, m;
            bit fb;
            c = VEC[v][35:20];
            m = VEC[v][19:4];
            fb = (c == 16'hFFFF);
            run_sel(c, m, lat);
            check(lat == (fb ? 2*NP : NP), "R10 latency", lat, fb ? 2*NP : NP);
            check(err == VEC[v][3], "R5 R6 err", err, VEC[v][3]);
            check(tap_sel == VEC[v][2:0], "R7 R8 tap", tap_sel, VEC[v][2:0]);
            @(negedge clk);
            check(!done && !err, "R10 pulse", {done, err}, 0);
        end

        // R9: start pulses during a selection are ignored
        @(negedge clk);
        start = 1'b1; cmd_ok = 16'h0E0E; cmp_ok = '0;  // taps 1..3 -> tap 2
        @(negedge clk);
        start = 1'b0;
        ndone = 0;
        for (int k = 0; k < 50; k++) begin
            if (k == 3 || k == 9) begin
                start = 1'b1; cmd_ok = 16'hC0C0;  // would be an error
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            if (done) begin
                ndone++;
                check(!err && tap_sel == 2, "R9 first request wins", tap_sel, 2);
            end
        end
        start = 1'b0;
        check(ndone == 1, "R9 single completion", ndone, 1);
        check(!busy, "R9 idle after", busy, 0);

        // R1: reset mid-scan returns to idle and clears tap
        run_sel(16'h3C3C, 16'h0000, lat);
        check(tap_sel == 3, "R7 before reset", tap_sel, 3);
        @(negedge clk);
        start = 1'b1; cmd_ok = 16'h3C3C;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && tap_sel == 0, "R1 reset mid-scan", {busy, tap_sel}, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(!done && !busy, "R1 stays idle", {done, busy}, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule